// File: doc/BRIEF.md
# SWCLK Programmable Rate Divider

This block derives the serial debug clock from the system clock through an integer divisor. A requester asks for a divisor. The block rounds the request to the nearest legal divisor whose rate does not exceed the requested one, and answers with the divisor that results. A query-only request returns the divisor in effect and changes nothing. Each legal divisor is even, so the high and low phases of the generated clock are always equal in length.

The transaction queue drives a pending flag that controls when a change takes effect. A slower rate (a larger divisor) is loaded at the next period boundary whatever the queue holds. A faster rate (a smaller divisor) is parked in a shadow register. It is loaded only at a period boundary where the queue is empty, so queued transfers keep the timing they were issued under. Two state machines do the work. The phase generator has the states PH_LOW and PH_HIGH: it moves from PH_LOW to PH_HIGH after half a period and from PH_HIGH back to PH_LOW at the period end. The request controller has three states. RQ_IDLE means nothing is staged. RQ_SLOW means a slower divisor is staged; it returns to RQ_IDLE at the next period end. RQ_HOLD means a faster divisor is held; it returns to RQ_IDLE at the first period end with the queue empty. Any set request moves the controller to RQ_HOLD, RQ_SLOW or RQ_IDLE, depending on how the rounded divisor compares with the one in effect.

Top module: `swclk_rate_div`

## Requirements
- R1: After reset, swclk is low, cur_div equals RST_DIV (16 by default), rate_held is 0, and rsp_valid, sw_rise and sw_fall are 0.
- R2: An odd requested divisor inside the legal range is rounded up to the next even value, which gives the nearest rate not above the request.
- R3: A requested divisor below DIV_MIN (2) is clamped to DIV_MIN. A request above DIV_MAX (64) is clamped to DIV_MAX. cur_div is always even and lies within that range.
- R4: rsp_valid pulses for one cycle, in the cycle after req_valid. For a set request, rsp_div then carries the rounded divisor.
- R5: A query (req_query=1 with req_valid) returns the divisor in effect on rsp_div. It changes neither cur_div nor rate_held.
- R6: A set request with a smaller divisor than cur_div raises rate_held. The new divisor is not loaded while txn_pending is high. It is loaded at the first period end after txn_pending goes low.
- R7: A set request with a larger divisor than cur_div is loaded at the next period end, even while txn_pending is high.
- R8: A later set request replaces a held divisor before that divisor is loaded.
- R9: Each low phase and each high phase lasts exactly cur_div/2 system clocks. A new divisor is loaded only where swclk falls, at the end of a high phase.
- R10: sw_rise is high only in the first cycle that swclk is high. sw_fall is high only in the first cycle that swclk is low after a high phase.
- R11: A set request equal to cur_div drops any held divisor, and rate_held returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_query | input | 1 | With req_valid: query only, no change |
| req_div | input | DIV_W | Requested divisor in system clocks per period |
| txn_pending | input | 1 | High while the transaction queue holds work |
| swclk | output | 1 | Generated serial clock |
| sw_rise | output | 1 | First cycle of each high phase |
| sw_fall | output | 1 | First cycle of each low phase |
| cur_div | output | DIV_W | Divisor currently in effect |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_div | output | DIV_W | Rounded divisor, or the divisor in effect for a query |
| rate_held | output | 1 | A faster divisor is waiting for the queue to drain |

## Verification
If the phase counter is wrong, the next swclk level has the wrong length. This appears within one half period, because the phase lengths are measured against cur_div. If the controller state is wrong, the bench sees one of three things within one full period of the slowest divisor: rate_held takes the wrong value in the cycle after the request, a faster divisor loads while the queue is busy, or a slower divisor fails to load. Rounding and clamping errors appear on rsp_div in the cycle after the request.

// File: rtl/swclk_rate_pkg.sv
package swclk_rate_pkg;

    typedef enum logic {
        PH_LOW,
        PH_HIGH
    } phase_e;

    typedef enum logic [1:0] {
        RQ_IDLE,
        RQ_SLOW,
        RQ_HOLD
    } rq_state_e;

endpackage

// File: rtl/swclk_div_round.sv
module swclk_div_round #(
    parameter int DIV_W   = 8,
    parameter int DIV_MIN = 2,
    parameter int DIV_MAX = 64
) (
    input  logic [DIV_W-1:0] raw_div,
    output logic [DIV_W-1:0] fit_div
);
    localparam logic [DIV_W-1:0] MIN_V = DIV_W'(DIV_MIN);
    localparam logic [DIV_W-1:0] MAX_V = DIV_W'(DIV_MAX);

    // Legal divisors are even; an odd one moves up (slower), never down.
    always_comb begin
        if (raw_div < MIN_V) begin
            fit_div = MIN_V;
        end else if (raw_div > MAX_V) begin
            fit_div = MAX_V;
        end else if (raw_div[0]) begin
            fit_div = raw_div + DIV_W'(1);
        end else begin
            fit_div = raw_div;
        end
    end
endmodule

// File: rtl/swclk_phase_gen.sv
module swclk_phase_gen
    import swclk_rate_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             swclk,
    output logic             sw_rise,
    output logic             sw_fall,
    output logic             period_end
);
    localparam int HW = DIV_W - 1;

    phase_e        state_q, state_d;
    logic [HW-1:0] cnt_q, cnt_d;
    logic          edge_q, edge_d;
    logic [HW-1:0] half;
    logic          last;

    assign half = div[DIV_W-1:1];
    assign last = (cnt_q == half - HW'(1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + HW'(1);
        edge_d  = 1'b0;
        unique case (state_q)
            PH_LOW: begin
                if (last) begin
                    state_d = PH_HIGH;
                    cnt_d   = '0;
                    edge_d  = 1'b1;
                end
            end
            PH_HIGH: begin
                if (last) begin
                    state_d = PH_LOW;
                    cnt_d   = '0;
                    edge_d  = 1'b1;
                end
            end
            default: begin
                state_d = PH_LOW;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_LOW;
            cnt_q   <= '0;
            edge_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            edge_q  <= edge_d;
        end
    end

    // Outputs
    always_comb begin
        swclk      = (state_q == PH_HIGH);
        sw_rise    = edge_q && (state_q == PH_HIGH);
        sw_fall    = edge_q && (state_q == PH_LOW);
        period_end = (state_q == PH_HIGH) && last;
    end
endmodule

// File: rtl/swclk_rate_ctrl.sv
module swclk_rate_ctrl
    import swclk_rate_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int RST_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_query,
    input  logic [DIV_W-1:0] fit_div,
    input  logic             txn_pending,
    input  logic             period_end,
    output logic [DIV_W-1:0] cur_div,
    output logic             rate_held,
    output logic             rsp_valid,
    output logic [DIV_W-1:0] rsp_div
);
    rq_state_e        st_q, st_d;
    logic [DIV_W-1:0] stg_q, stg_d;
    logic [DIV_W-1:0] cur_q;
    logic             load;
    logic             set_req;

    assign set_req = req_valid && !req_query;

    // Next-state logic; a fresh request wins over a load in the same cycle.
    always_comb begin
        st_d  = st_q;
        stg_d = stg_q;
        load  = 1'b0;
        if (set_req) begin
            stg_d = fit_div;
            if (fit_div < cur_q) begin
                st_d = RQ_HOLD;
            end else if (fit_div > cur_q) begin
                st_d = RQ_SLOW;
            end else begin
                st_d = RQ_IDLE;
            end
        end else begin
            unique case (st_q)
                RQ_IDLE: begin
                    st_d = RQ_IDLE;
                end
                RQ_SLOW: begin
                    if (period_end) begin
                        load = 1'b1;
                        st_d = RQ_IDLE;
                    end
                end
                RQ_HOLD: begin
                    if (period_end && !txn_pending) begin
                        load = 1'b1;
                        st_d = RQ_IDLE;
                    end
                end
                default: begin
                    st_d = RQ_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= RQ_IDLE;
            stg_q     <= DIV_W'(RST_DIV);
            cur_q     <= DIV_W'(RST_DIV);
            rsp_valid <= 1'b0;
            rsp_div   <= '0;
        end else begin
            st_q      <= st_d;
            stg_q     <= stg_d;
            if (load) begin
                cur_q <= stg_q;
            end
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_div <= req_query ? cur_q : fit_div;
            end
        end
    end

    // Outputs
    always_comb begin
        cur_div   = cur_q;
        rate_held = (st_q == RQ_HOLD);
    end
endmodule

// File: rtl/swclk_rate_div.sv
module swclk_rate_div #(
    parameter int DIV_W   = 8,
    parameter int DIV_MIN = 2,
    parameter int DIV_MAX = 64,
    parameter int RST_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_query,
    input  logic [DIV_W-1:0] req_div,
    input  logic             txn_pending,
    output logic             swclk,
    output logic             sw_rise,
    output logic             sw_fall,
    output logic [DIV_W-1:0] cur_div,
    output logic             rsp_valid,
    output logic [DIV_W-1:0] rsp_div,
    output logic             rate_held
);
    logic [DIV_W-1:0] fit_div;
    logic             period_end;

    swclk_div_round #(
        .DIV_W  (DIV_W),
        .DIV_MIN(DIV_MIN),
        .DIV_MAX(DIV_MAX)
    ) u_round (
        .raw_div(req_div),
        .fit_div(fit_div)
    );

    swclk_rate_ctrl #(
        .DIV_W  (DIV_W),
        .RST_DIV(RST_DIV)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_query  (req_query),
        .fit_div    (fit_div),
        .txn_pending(txn_pending),
        .period_end (period_end),
        .cur_div    (cur_div),
        .rate_held  (rate_held),
        .rsp_valid  (rsp_valid),
        .rsp_div    (rsp_div)
    );

    swclk_phase_gen #(
        .DIV_W(DIV_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (cur_div),
        .swclk     (swclk),
        .sw_rise   (sw_rise),
        .sw_fall   (sw_fall),
        .period_end(period_end)
    );
endmodule

// File: rtl/swclk_rate_checker.sv
module swclk_rate_checker #(
    parameter int DIV_W   = 8,
    parameter int DIV_MIN = 2,
    parameter int DIV_MAX = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_query,
    input logic             txn_pending,
    input logic             swclk,
    input logic [DIV_W-1:0] cur_div,
    input logic             rsp_valid,
    input logic [DIV_W-1:0] rsp_div
);
    logic             prev_sw;
    logic [DIV_W-1:0] run_len;

    // Length of the level that just ended, counted in system clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sw <= 1'b0;
            run_len <= '0;
        end else begin
            prev_sw <= swclk;
            if (swclk != prev_sw) begin
                run_len <= DIV_W'(1);
            end else begin
                run_len <= run_len + DIV_W'(1);
            end
        end
    end

    AST_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (swclk != prev_sw) |-> (run_len == ($past(cur_div) >> 1))); // R9

    AST_LOAD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_div != $past(cur_div)) |-> $fell(swclk)); // R9

    AST_NO_FAST_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_div < $past(cur_div)) |-> !$past(txn_pending)); // R6

    AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_div >= DIV_W'(DIV_MIN)) && (cur_div <= DIV_W'(DIV_MAX)) && !cur_div[0]); // R3

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid)); // R4

    AST_QUERY_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_query) |-> (rsp_div == $past(cur_div))); // R5
endmodule

bind swclk_rate_div swclk_rate_checker #(
    .DIV_W  (DIV_W),
    .DIV_MIN(DIV_MIN),
    .DIV_MAX(DIV_MAX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_query  (req_query),
    .txn_pending(txn_pending),
    .swclk      (swclk),
    .cur_div    (cur_div),
    .rsp_valid  (rsp_valid),
    .rsp_div    (rsp_div)
);

// File: tb/swclk_rate_div_bench.sv
`timescale 1ns/1ps
module swclk_rate_div_bench;
    localparam int DIV_W  = 8;
    localparam int WAIT_N = 2 * 64 + 8;
    localparam int NV     = 9;

    // Vector table: request, query flag, expected rsp_div, expected cur_div after settling.
    localparam int V_REQ [NV] = '{10, 7, 33, 0, 200, 65, 0, 1, 12};
    localparam int V_QRY [NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 0};
    localparam int V_RSP [NV] = '{10, 8, 34, 2, 64, 64, 64, 2, 12};
    localparam int V_CUR [NV] = '{10, 8, 34, 2, 64, 64, 64, 2, 12};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_query = 1'b0;
    logic [DIV_W-1:0] req_div = '0;
    logic             txn_pending = 1'b0;
    logic             swclk, sw_rise, sw_fall, rsp_valid, rate_held;
    logic [DIV_W-1:0] cur_div, rsp_div;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    swclk_rate_div u_swclk_rate_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_query  (req_query),
        .req_div    (req_div),
        .txn_pending(txn_pending),
        .swclk      (swclk),
        .sw_rise    (sw_rise),
        .sw_fall    (sw_fall),
        .cur_div    (cur_div),
        .rsp_valid  (rsp_valid),
        .rsp_div    (rsp_div),
        .rate_held  (rate_held)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Issue one request at a falling edge and check the response one cycle on.
    task automatic send(input int d, input int q, input int exp_rsp, input string tag);
        req_div   = d[DIV_W-1:0];
        req_query = (q != 0);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_query = 1'b0;
        chk({tag, " rsp_valid"}, int'(rsp_valid), 1);
        chk({tag, " rsp_div"}, int'(rsp_div), exp_rsp);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int hi_n;
        int lo_n;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 swclk", int'(swclk), 0);
        chk("R1 cur_div", int'(cur_div), 16);
        chk("R1 rate_held", int'(rate_held), 0);
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 sw_rise", int'(sw_rise), 0);
        chk("R1 sw_fall", int'(sw_fall), 0);

        // Table walk (R2 R3 R4 R5 R7 with the queue empty)
        for (int k = 0; k < NV; k++) begin
            send(V_REQ[k], V_QRY[k], V_RSP[k], "R2_R3_R4 vec");
            idle(WAIT_N);
            chk("R5_R7 vec cur_div", int'(cur_div), V_CUR[k]);
        end

        // R9 R10: phase lengths at divisor 10
        send(10, 0, 10, "R9 set");
        idle(WAIT_N);
        while (!(swclk && sw_rise)) @(negedge clk);
        hi_n = 0;
        while (swclk) begin
            if (hi_n == 1) chk("R10 sw_rise second cycle", int'(sw_rise), 0);
            hi_n++;
            @(negedge clk);
        end
        chk("R10 sw_fall first low", int'(sw_fall), 1);
        lo_n = 0;
        while (!swclk) begin
            lo_n++;
            @(negedge clk);
        end
        chk("R9 high length", hi_n, 5);
        chk("R9 low length", lo_n, 5);

        // R6: faster held while queue busy
        send(20, 0, 20, "R6 base");
        idle(WAIT_N);
        txn_pending = 1'b1;
        send(6, 0, 6, "R6 faster");
        chk("R6 rate_held", int'(rate_held), 1);
        idle(WAIT_N);
        chk("R6 cur_div kept", int'(cur_div), 20);
        // R5: query during hold
        send(0, 1, 20, "R5 query");
        chk("R5 rate_held kept", int'(rate_held), 1);
        chk("R5 cur_div kept", int'(cur_div), 20);
        // R8: overwrite shadow
        send(9, 0, 10, "R8 overwrite");
        idle(WAIT_N);
        chk("R8 cur_div still held", int'(cur_div), 20);
        txn_pending = 1'b0;
        idle(WAIT_N);
        chk("R8 cur_div after drain", int'(cur_div), 10);
        chk("R6 rate_held cleared", int'(rate_held), 0);

        // R7: slower applies while busy
        txn_pending = 1'b1;
        send(40, 0, 40, "R7 slower");
        chk("R7 rate_held", int'(rate_held), 0);
        idle(WAIT_N);
        chk("R7 cur_div", int'(cur_div), 40);

        // R11: equal request cancels held change
        send(4, 0, 4, "R11 faster");
        chk("R11 held set", int'(rate_held), 1);
        send(40, 0, 40, "R11 equal");
        chk("R11 held cleared", int'(rate_held), 0);
        txn_pending = 1'b0;
        idle(WAIT_N);
        chk("R11 cur_div", int'(cur_div), 40);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule